// File: doc/BRIEF.md
# Dual-Point PWM Channel Generator

This block produces one pulse-width-modulated pad signal. Its time base is a prescaler. The prescaler makes a quantum tick every `(div_lin + 1) << div_exp` input clock cycles. An 8-bit period counter counts these ticks. The output is active inside a window of counts that runs from a programmable rising point up to a falling point. The window may also wrap across the end of the period. When the two points are equal, the output is active all the time.

The configuration pins are meant to be driven from a register file. The period, rising point and falling point are copied into shadow registers at each period boundary. This means a new duty or a new period does not produce a mixed, glitchy cycle. A sync-disable input makes the block use the configuration pins directly. The run enable holds the counters at zero while it is low. The pin enable, the polarity invert and the open-drain mode act at the output with no delay.

The sequencer has two states. `ST_HALT` is entered at reset and whenever `clk_en` is low: the counters are held at zero and the internal level is inactive. The transition `ST_HALT -> ST_RUN` happens when `clk_en` is seen high. On that transition the shadows are loaded and counting starts from zero. The transition `ST_RUN -> ST_HALT` happens when `clk_en` is seen low.

Top module: `pwm_dualpoint_gen`

## Requirements
- R1: One quantum lasts `(div_lin + 1) * 2^div_exp` clock cycles.
- R2: One PWM period lasts `per_len + 1` quanta.
- R3: The internal level is active for counts c where `rise_pt <= c < fall_pt` when `rise_pt < fall_pt`. When `rise_pt > fall_pt`, it is active where `c >= rise_pt` or `c < fall_pt`. The active level is 1 on `pwm_out` when `invert` is 0.
- R4: When `rise_pt == fall_pt`, the output stays active for the whole period (100% duty).
- R5: While `clk_en` is low, the counters are zero and the output is inactive (0% duty). After `clk_en` rises, the first period is full length and starts with count 0, using the configuration present at that moment.
- R6: When `pin_en` is low, `pwm_out` is at the inactive level in the same cycle, whatever the counter holds.
- R7: `invert` flips `pwm_out` combinationally, with no wait for a boundary. The inactive level equals the value of `invert`.
- R8: With `sync_dis` = 0, a change to the period, rising point or falling point first takes effect in the period that follows.
- R9: With `sync_dis` = 1, the period, rising point and falling point pins are used directly, in the same cycle.
- R10: With `od_en` = 1, `pwm_oe` is 1 only when `pwm_out` is 0. With `od_en` = 0, `pwm_oe` is always 1.
- R11: After reset with `clk_en` low, `pwm_out` = 0 and `pwm_oe` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_lin | input | 8 | Linear prescale value; the quantum is multiplied by div_lin+1 |
| div_exp | input | 4 | Power-of-two prescale exponent |
| per_len | input | 8 | Period length minus one, in quanta |
| rise_pt | input | 8 | Count at which the active window opens |
| fall_pt | input | 8 | Count at which the active window closes |
| clk_en | input | 1 | Run enable; low holds the counters at zero |
| pin_en | input | 1 | Pin enable; low forces the inactive level |
| invert | input | 1 | Output polarity invert |
| od_en | input | 1 | Open-drain output-enable mode |
| sync_dis | input | 1 | Use the waveform configuration directly, not the shadows |
| pwm_out | output | 1 | Pad output level |
| pwm_oe | output | 1 | Pad output enable |

## Verification
The hardest condition to reach is a configuration change in the middle of a period. The shadow registers have to keep the old falling point until the boundary. The bench waits for the sampled rising edge, which marks count zero. In that same cycle it moves the falling point. It then counts the active cycles of the current period and of the next period separately. It repeats this with `sync_dis` set, where the change must shorten or stretch the current period. The wrapped window (rising point above falling point) is also tested. It is measured from a rising edge inside the period rather than from the boundary.

// File: rtl/pwm_dp_pkg.sv
package pwm_dp_pkg;

    localparam int WAVE_W = 8;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef struct packed {
        logic [WAVE_W-1:0] period;
        logic [WAVE_W-1:0] rise;
        logic [WAVE_W-1:0] fall;
    } wave_cfg_t;

endpackage

// File: rtl/pwm_dp_prescaler.sv
module pwm_dp_prescaler #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LIN_W-1:0] lin,
    input  logic [EXP_W-1:0] expo,
    output logic             tick
);
    localparam int PRE_W = LIN_W + 1 + (2**EXP_W - 1);

    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] pre_q;

    always_comb begin
        limit = ({{(PRE_W-LIN_W){1'b0}}, lin} + PRE_W'(1)) << expo;
        tick  = run && (pre_q >= limit - PRE_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (!run || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end

    // R1: with a steady divider the prescale count stays below one quantum
    a_r1_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(lin) && $stable(expo)) |-> (pre_q < limit));

endmodule

// File: rtl/pwm_dp_sequencer.sv
module pwm_dp_sequencer
    import pwm_dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              sync_dis,
    input  logic              tick,
    input  wave_cfg_t         cfg,
    output logic              run,
    output logic [WAVE_W-1:0] cnt,
    output wave_cfg_t         eff
);
    run_state_t        state_q, state_d;
    logic [WAVE_W-1:0] cnt_q;
    wave_cfg_t         act_q;
    logic              wrap;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (clk_en)  state_d = ST_RUN;
            ST_RUN:  if (!clk_en) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        run  = (state_q == ST_RUN);
        eff  = sync_dis ? cfg : act_q;
        wrap = run && tick && (cnt_q >= eff.period);
        cnt  = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (state_d == ST_HALT) begin
            cnt_q <= '0;
        end else if (state_q == ST_HALT) begin
            cnt_q <= '0;
            act_q <= cfg;
        end else begin
            if (wrap)      cnt_q <= '0;
            else if (tick) cnt_q <= cnt_q + WAVE_W'(1);
            if (wrap || sync_dis) act_q <= cfg;
        end
    end

    // R5: a low run enable leaves the period counter at zero
    a_r5_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> (cnt_q == '0));

    // R8: in synchronous mode the shadows change only at a boundary
    a_r8_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (run && clk_en && !sync_dis && !wrap) |=> $stable(act_q));

endmodule

// File: rtl/pwm_dp_outstage.sv
module pwm_dp_outstage
    import pwm_dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WAVE_W-1:0] cnt,
    input  logic [WAVE_W-1:0] rise,
    input  logic [WAVE_W-1:0] fall,
    input  logic              pin_en,
    input  logic              invert,
    input  logic              od_en,
    output logic              pin,
    output logic              oe
);
    logic in_win;
    logic lvl;

    always_comb begin
        if (rise == fall)
            in_win = 1'b1;
        else if (rise < fall)
            in_win = (cnt >= rise) && (cnt < fall);
        else
            in_win = (cnt >= rise) || (cnt < fall);
        lvl = run && in_win;
        pin = (pin_en && lvl) ^ invert;
        oe  = od_en ? ~pin : 1'b1;
    end

    // R4: equal points keep the internal level active while running
    a_r4_equal_full: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (rise == fall)) |-> lvl);

    // R6: a disabled pin sits at the inactive level
    a_r6_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |-> (pin == invert));

    // R10: open-drain mode never drives a high level
    a_r10_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        (od_en && pin) |-> !oe);

endmodule

// File: rtl/pwm_dualpoint_gen.sv
module pwm_dualpoint_gen
    import pwm_dp_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LIN_W-1:0]  div_lin,
    input  logic [EXP_W-1:0]  div_exp,
    input  logic [WAVE_W-1:0] per_len,
    input  logic [WAVE_W-1:0] rise_pt,
    input  logic [WAVE_W-1:0] fall_pt,
    input  logic              clk_en,
    input  logic              pin_en,
    input  logic              invert,
    input  logic              od_en,
    input  logic              sync_dis,
    output logic              pwm_out,
    output logic              pwm_oe
);
    wave_cfg_t         cfg;
    wave_cfg_t         eff;
    logic              run;
    logic              tick;
    logic [WAVE_W-1:0] cnt;

    always_comb begin
        cfg.period = per_len;
        cfg.rise   = rise_pt;
        cfg.fall   = fall_pt;
    end

    pwm_dp_prescaler #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run),
        .lin(div_lin), .expo(div_exp), .tick(tick)
    );

    pwm_dp_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sync_dis(sync_dis),
        .tick(tick), .cfg(cfg), .run(run), .cnt(cnt), .eff(eff)
    );

    pwm_dp_outstage u_out (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
        .rise(eff.rise), .fall(eff.fall),
        .pin_en(pin_en), .invert(invert), .od_en(od_en),
        .pin(pwm_out), .oe(pwm_oe)
    );

endmodule

// File: tb/sim_pwm_dualpoint_gen.sv
module sim_pwm_dualpoint_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_lin = '0;
    logic [3:0] div_exp = '0;
    logic [7:0] per_len = '0, rise_pt = '0, fall_pt = '0;
    logic       clk_en = 1'b0, pin_en = 1'b0, invert = 1'b0, od_en = 1'b0, sync_dis = 1'b0;
    logic       pwm_out, pwm_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwm_dualpoint_gen u0 (
        .clk(clk), .rst_n(rst_n), .div_lin(div_lin), .div_exp(div_exp),
        .per_len(per_len), .rise_pt(rise_pt), .fall_pt(fall_pt),
        .clk_en(clk_en), .pin_en(pin_en), .invert(invert), .od_en(od_en),
        .sync_dis(sync_dis), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    // {div_exp, div_lin, per_len, fall_pt, expected high cycles, expected period cycles}
    localparam int NV = 6;
    localparam int VEC [NV][6] = '{
        '{0, 0,   9,   3,   3,  10},
        '{0, 2,   4,   2,   6,  15},
        '{2, 1,   3,   1,   8,  32},
        '{1, 4,   7,   5,  50,  80},
        '{0, 0, 255, 128, 128, 256},
        '{3, 0,   2,   2,  16,  24}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // waits for a low, then a rising edge, then counts high and low cycles
    task automatic measure(output int hi, output int per);
        int lo;
        hi = 0; lo = 0;
        @(negedge clk);
        while (pwm_out !== 1'b0) @(negedge clk);
        while (pwm_out !== 1'b1) @(negedge clk);
        while (pwm_out === 1'b1) begin hi++; @(negedge clk); end
        while (pwm_out === 1'b0) begin lo++; @(negedge clk); end
        per = hi + lo;
    endtask

    task automatic setup(input int e, input int l, input int p, input int r, input int f);
        @(negedge clk);
        clk_en  = 1'b0;
        div_exp = 4'(e); div_lin = 8'(l);
        per_len = 8'(p); rise_pt = 8'(r); fall_pt = 8'(f);
        repeat (2) @(negedge clk);
        clk_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int hi, per, cnt_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pin_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 reset out", int'(pwm_out), 0);
        chk("R11 reset oe", int'(pwm_oe), 1);

        // table walk: R1 quantum, R2 period, R3 window from rise 0
        for (int i = 0; i < NV; i++) begin
            setup(VEC[i][0], VEC[i][1], VEC[i][2], 0, VEC[i][3]);
            measure(hi, per);
            chk($sformatf("R1 R3 high vec%0d", i), hi, VEC[i][4]);
            chk($sformatf("R1 R2 period vec%0d", i), per, VEC[i][5]);
        end

        // R3 nonzero rising point and wrapped window
        setup(0, 0, 9, 2, 5);
        measure(hi, per);
        chk("R3 window 2..5 high", hi, 3);
        chk("R3 window 2..5 period", per, 10);
        setup(0, 0, 9, 6, 2);
        measure(hi, per);
        chk("R3 wrapped high", hi, 6);
        chk("R3 wrapped period", per, 10);

        // R4 equal points
        setup(1, 0, 5, 4, 4);
        repeat (2) @(negedge clk);
        cnt_hi = 0;
        for (int k = 0; k < 300; k++) begin
            if (pwm_out === 1'b1) cnt_hi++;
            @(negedge clk);
        end
        chk("R4 full duty samples", cnt_hi, 300);

        // R5 disabled: inactive, and first period after enable is full length
        @(negedge clk);
        clk_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 halted out", int'(pwm_out), 0);
        invert = 1'b1;
        #1;
        chk("R7 halted inactive inverted", int'(pwm_out), 1);
        @(negedge clk);
        invert = 1'b0;
        setup(0, 2, 4, 0, 2);
        @(negedge clk);
        cnt_hi = 0;
        while (pwm_out === 1'b1) begin cnt_hi++; @(negedge clk); end
        chk("R5 first period high", cnt_hi, 6);

        // R6 / R7 / R10 while running
        setup(0, 0, 9, 0, 3);
        @(negedge clk);
        while (pwm_out !== 1'b1) @(negedge clk);
        invert = 1'b1;
        #1;
        chk("R7 invert immediate", int'(pwm_out), 0);
        invert = 1'b0;
        pin_en = 1'b0;
        #1;
        chk("R6 pin off immediate", int'(pwm_out), 0);
        invert = 1'b1;
        #1;
        chk("R6 pin off inverted", int'(pwm_out), 1);
        invert = 1'b0;
        pin_en = 1'b1;
        od_en = 1'b1;
        #1;
        chk("R10 od high oe", int'(pwm_oe), 0);
        while (pwm_out !== 1'b0) @(negedge clk);
        chk("R10 od low oe", int'(pwm_oe), 1);
        od_en = 1'b0;
        while (pwm_out !== 1'b1) @(negedge clk);
        chk("R10 push-pull oe", int'(pwm_oe), 1);

        // R8 synchronous update: current period keeps old falling point
        @(negedge clk);
        while (pwm_out !== 1'b0) @(negedge clk);
        while (pwm_out !== 1'b1) @(negedge clk);
        fall_pt = 8'd7;
        cnt_hi = 0;
        while (pwm_out === 1'b1) begin cnt_hi++; @(negedge clk); end
        chk("R8 current period high", cnt_hi, 3);
        measure(hi, per);
        chk("R8 next period high", hi, 7);

        // R9 direct update
        fall_pt = 8'd3;
        measure(hi, per);
        sync_dis = 1'b1;
        while (pwm_out !== 1'b0) @(negedge clk);
        while (pwm_out !== 1'b1) @(negedge clk);
        fall_pt = 8'd6;
        cnt_hi = 0;
        while (pwm_out === 1'b1) begin cnt_hi++; @(negedge clk); end
        chk("R9 current period high", cnt_hi, 6);

        summary();
        $finish;
    end

endmodule